// File: doc/BRIEF.md
# I2C Master Clock Phase Generator

This block produces the serial clock for an I2C master. Two 8-bit length inputs set the clock's two phases separately. One sets how long the block pulls SCL down. The other sets how long SCL is left high once the line has actually risen. Each length unit is two reference clock cycles. The SCL frequency is therefore the reference clock (7.3728 MHz in the target system) divided by twice the sum of the two lengths, plus the few cycles the rise takes to be seen. Because the phases are set independently, the duty cycle can be tuned.

The block drives SCL only as an open-drain enable, and it reads the pad back through a synchronizer. A slave that holds the line low stretches the clock: the high phase is not counted until the pad is seen high. Two single-cycle strobes are provided for the data path. One comes in the middle of the low phase, when SDA may change. The other comes on the first counted cycle of the high phase, when SDA is sampled. The generator runs only while its enable is high. When the enable drops, SCL is released and the phase counter is cleared. Lengths below a minimum of 2 are raised to 2.

Top module: `scl_phase_gen`

## Requirements
- R1: During and after reset, with the enable low, the pull-down enable and both strobes are 0.
- R2: When the enable is seen high from idle, the pull-down enable rises on that clock edge and stays at 1 for exactly 2×L cycles. Here L is the effective low length.
- R3: The pad is read through a 2-stage synchronizer. With the pad following the driver at once, SCL stays released for exactly 2×H + 3 cycles before the next pull-down. Here H is the effective high length.
- R4: While the synchronized pad reads low after release, the generator keeps waiting and does not pull down. Each extra cycle the pad is held low lengthens the released interval by one cycle.
- R5: The SDA change strobe is high for one cycle in each low phase. It comes exactly L cycles after the pull-down enable rose.
- R6: The SDA sample strobe is high for one cycle in each high phase. It comes on the first counted high cycle, 3 cycles after release when the pad rises at once.
- R7: A length input of 0 or 1 acts as 2, so that no phase is shorter than 4 cycles.
- R8: One clock edge after the enable is seen low, in any phase, SCL is released and the strobes are 0. On the next enable, the sequence restarts with a full low phase.
- R9: The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Generator enable |
| high_len_i | input | 8 | High phase length, in units of two clocks |
| low_len_i | input | 8 | Low phase length, in units of two clocks |
| scl_pad_i | input | 1 | SCL pad level read back |
| scl_drive_low_o | output | 1 | 1 = pull SCL low (open-drain enable) |
| sda_change_stb_o | output | 1 | Mid-low-phase strobe for changing SDA |
| sda_sample_stb_o | output | 1 | High-phase-start strobe for sampling SDA |

## Verification
Several properties are checked on every cycle: release within one edge of disable, strobes that never coincide, no pull-down while a stretched line is still low, a sample strobe only with the pad seen high, a phase counter kept within its programmed limit, and no one-cycle pull-down pulse. The exact phase lengths, the strobe offsets, the clamping of small lengths and the extra time added by a stretching slave are arithmetic over whole periods. Only the bench's scenarios can show these, measuring intervals at the ports against values worked out from the programmed lengths.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;

  localparam int unsigned NUM_PHASES = 2;
  localparam int unsigned IDX_LOW    = 0;
  localparam int unsigned IDX_HIGH   = 1;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/scl_pad_sync.sv
module scl_pad_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  output logic level_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pad_i};
  end

  // released bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= sync_d;
  end

  assign level_o = sync_q[STAGES-1];

endmodule

// File: rtl/scl_len_clamp.sv
module scl_len_clamp #(
  parameter int unsigned W       = 8,
  parameter int unsigned MIN_LEN = 2
) (
  input  logic [W-1:0] len_i,
  output logic [W-1:0] len_o
);

  localparam logic [W-1:0] MinV = W'(MIN_LEN);

  always_comb begin
    if (len_i < MinV) len_o = MinV;
    else              len_o = len_i;
  end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         count_en_i,
  input  logic [W-1:0] half_len_i,
  output logic         first_o,
  output logic         mid_o,
  output logic         last_o
);

  localparam int unsigned CW = W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;
  logic          cnt_we;

  // each length unit is two reference cycles
  assign limit = {half_len_i, 1'b0} - 1'b1;

  always_comb begin
    cnt_we = clear_i | count_en_i;
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign first_o = (cnt_q == '0);
  assign mid_o   = (cnt_q == {1'b0, half_len_i});
  assign last_o  = (cnt_q == limit);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit); // R2

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned MIN_LEN     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic             scl_pad_i,
  output logic             scl_drive_low_o,
  output logic             sda_change_stb_o,
  output logic             sda_sample_stb_o
);

  logic             rst_sync_n;
  logic             pad_hi;
  logic [LEN_W-1:0] len_raw [NUM_PHASES];
  logic [LEN_W-1:0] len_eff [NUM_PHASES];
  logic [LEN_W-1:0] cur_len;
  scl_state_e       state_q;
  scl_state_e       state_d;
  logic             counting;
  logic             tmr_clear;
  logic             tmr_first;
  logic             tmr_mid;
  logic             tmr_last;

  scl_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  scl_pad_sync #(.STAGES(SYNC_STAGES)) i_pad_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .pad_i   (scl_pad_i),
    .level_o (pad_hi)
  );

  assign len_raw[IDX_LOW]  = low_len_i;
  assign len_raw[IDX_HIGH] = high_len_i;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_clamp
    scl_len_clamp #(.W(LEN_W), .MIN_LEN(MIN_LEN)) i_clamp (
      .len_i (len_raw[g]),
      .len_o (len_eff[g])
    );
  end

  assign cur_len = (state_q == ST_HIGH) ? len_eff[IDX_HIGH] : len_eff[IDX_LOW];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (run_en_i) state_d = ST_LOW;
      ST_LOW: begin
        if (!run_en_i)     state_d = ST_IDLE;
        else if (tmr_last) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!run_en_i)   state_d = ST_IDLE;
        else if (pad_hi) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (!run_en_i)     state_d = ST_IDLE;
        else if (tmr_last) state_d = ST_LOW;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_comb begin
    counting  = (state_q == ST_LOW) || (state_q == ST_HIGH);
    tmr_clear = !counting || (state_d != state_q);
  end

  scl_phase_timer #(.W(LEN_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .clear_i    (tmr_clear),
    .count_en_i (counting),
    .half_len_i (cur_len),
    .first_o    (tmr_first),
    .mid_o      (tmr_mid),
    .last_o     (tmr_last)
  );

  assign scl_drive_low_o  = (state_q == ST_LOW);
  assign sda_change_stb_o = (state_q == ST_LOW)  && tmr_mid;
  assign sda_sample_stb_o = (state_q == ST_HIGH) && tmr_first;

  AST_RELEASE_ON_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !run_en_i |=> !scl_drive_low_o); // R8

  AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(sda_change_stb_o && sda_sample_stb_o)); // R9

  AST_STRETCH_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == ST_WAIT && !pad_hi && run_en_i) |=> (state_q == ST_WAIT)); // R4

  AST_SAMPLE_SEES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sda_sample_stb_o |-> pad_hi); // R6

  AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sda_sample_stb_o |=> !sda_sample_stb_o); // R6

  AST_LOW_NOT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (run_en_i && $rose(scl_drive_low_o)) |=> (scl_drive_low_o || !$past(run_en_i))); // R7

endmodule

// File: tb/test_scl_phase_gen.sv
`timescale 1ns/1ps
module test_scl_phase_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int K_CHG = 0;
  localparam int K_LOW = 1;
  localparam int K_SMP = 2;
  localparam int K_REL = 3;

  typedef struct {
    int    kind;
    int    value;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic [7:0] high_len;
  logic [7:0] low_len;
  logic       scl_pad;
  logic       drive_low;
  logic       chg_stb;
  logic       smp_stb;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   mon_on = 1'b0;
  int   stretch_cycles = 0;
  int   hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_phase_gen i_scl_phase_gen (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .run_en_i         (run_en),
    .high_len_i       (high_len),
    .low_len_i        (low_len),
    .scl_pad_i        (scl_pad),
    .scl_drive_low_o  (drive_low),
    .sda_change_stb_o (chg_stb),
    .sda_sample_stb_o (smp_stb)
  );

  // open-drain bus with pull-up and an optional stretching slave
  always @(negedge clk) begin
    if (drive_low)     hold <= stretch_cycles;
    else if (hold > 0) hold <= hold - 1;
  end
  assign scl_pad = !(drive_low || (hold > 0));

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report(int kind, int value);
    exp_t it;
    if (exp_q.size() == 0) begin
      total++;
      bad++;
      $display("FAIL R2 unexpected event kind=%0d: actual=%0d expected=none", kind, value);
    end else begin
      it = exp_q.pop_front();
      check(it.tag, kind, it.kind, "event kind");
      check(it.tag, value, it.value, "interval");
    end
  endtask

  // monitor: measures intervals at the ports and scores them
  int cyc = 0;
  int rise_cyc = 0;
  int fall_cyc = 0;
  bit prev_d = 1'b0;
  bit have_rise = 1'b0;
  bit have_fall = 1'b0;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (!mon_on) begin
        have_rise = 1'b0;
        have_fall = 1'b0;
      end else begin
        if (drive_low && !prev_d) begin
          if (have_fall) report(K_REL, cyc - fall_cyc);
          rise_cyc  = cyc;
          have_rise = 1'b1;
        end
        if (!drive_low && prev_d && have_rise) begin
          report(K_LOW, cyc - rise_cyc);
          fall_cyc  = cyc;
          have_fall = 1'b1;
        end
        if (chg_stb || smp_stb) check("R9", int'(chg_stb && smp_stb), 0, "strobe overlap");
        if (chg_stb && have_rise) report(K_CHG, cyc - rise_cyc);
        if (smp_stb && have_fall) report(K_SMP, cyc - fall_cyc);
      end
      prev_d = drive_low;
    end
  end

  task automatic push(int kind, int value, string tag);
    exp_t it;
    it.kind  = kind;
    it.value = value;
    it.tag   = tag;
    exp_q.push_back(it);
  endtask

  // driver: program lengths, queue expected intervals, run n periods
  task automatic run_case(int lo, int hi, int s, int n, string ovr);
    int eff_l;
    int eff_h;
    int extra;
    eff_l = (lo < 2) ? 2 : lo;
    eff_h = (hi < 2) ? 2 : hi;
    extra = (s > 0) ? s - 1 : 0;
    @(negedge clk);
    low_len        = 8'(lo);
    high_len       = 8'(hi);
    stretch_cycles = s;
    for (int p = 0; p < n; p++) begin
      push(K_CHG, eff_l, (ovr != "") ? ovr : "R5");
      push(K_LOW, 2 * eff_l, (ovr != "") ? ovr : "R2");
      push(K_SMP, 3 + extra, (s > 0) ? "R4" : "R6");
      push(K_REL, 2 * eff_h + 3 + extra, (s > 0) ? "R4" : "R3");
    end
    mon_on = 1'b1;
    run_en = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    run_en = 1'b0;
    @(negedge clk);
    check("R8", int'(drive_low), 0, "drive after disable");
    check("R8", int'(chg_stb || smp_stb), 0, "strobes after disable");
    repeat (s + 4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    run_en   = 1'b0;
    high_len = 8'd4;
    low_len  = 8'd4;
    repeat (5) @(negedge clk);
    check("R1", int'(drive_low), 0, "drive in reset");
    check("R1", int'(chg_stb || smp_stb), 0, "strobes in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", int'(drive_low), 0, "drive idle after reset");
    check("R1", int'(chg_stb || smp_stb), 0, "strobes idle after reset");

    run_case(4, 6, 0, 3, "");      // R2 R3 R5 R6 balanced-ish
    run_case(10, 3, 0, 2, "");     // R2 R3 long low
    run_case(3, 5, 5, 2, "");      // R4 stretched by slave
    run_case(3, 3, 9, 1, "");      // R4 longer stretch
    run_case(1, 0, 0, 2, "R7");    // R7 clamped lengths
    run_case(0, 1, 0, 1, "R7");    // R7 zero low length

    // R8: disable in the middle of a low phase, then restart fully
    @(negedge clk);
    low_len  = 8'd8;
    high_len = 8'd2;
    run_en   = 1'b1;
    repeat (5) @(negedge clk);
    check("R8", int'(drive_low), 1, "drive mid low");
    run_en = 1'b0;
    @(negedge clk);
    check("R8", int'(drive_low), 0, "release mid low");
    repeat (3) @(negedge clk);
    run_case(8, 2, 0, 1, "R8");

    run_case(200, 150, 0, 1, "");  // R2 R3 wide lengths

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule